// File: doc/BRIEF.md
# CPU Clock Source Switching Sequencer

This block steers a two-level clock selection tree that feeds a CPU while the CPU frequency changes. A two-input secondary selector chooses between the crystal reference and the primary PLL divided by two. A four-input primary selector chooses between the secondary selector output, the primary PLL early output, a droop-control path and an alternate PLL. The analog PLLs and the glitch-free switching cells are outside the block. Their lock and switch-acknowledge indications reach it as handshake inputs.

When a rate request arrives, the block first parks the CPU on the alternate PLL. It then commands the primary PLL to a VCO rate inside its legal range and waits a programmable number of cycles for lock. Last, it sets the secondary selector and returns the primary selector to the primary PLL path. The primary VCO cannot run below 600 MHz. A target between 300 and 599 MHz is therefore built by locking at twice the target and passing through the divide-by-two input. A target that cannot be built is refused. A PLL that fails to lock leaves the CPU on the alternate source and sets an error flag.

Top module: `cpu_clk_seq`

## Requirements
- R1: After reset, `smux_sel` is 0 (crystal reference), `pmux_sel` is 0 (secondary selector output), and `busy`, `done`, `pll_prog`, `err_range` and `err_lock` are all 0.
- R2: A request taken while idle whose `req_mhz` is below 300 or above 3000 raises `err_range` for exactly one cycle. It changes neither selector, does not raise `busy` and issues no `pll_prog`.
- R3: A request taken while idle with `req_mhz` from 300 to 3000 inclusive sets `pmux_sel` to 3 (alternate PLL) and raises `busy` on the next clock edge.
- R4: After the primary selector is on input 3, the block pulses `pll_prog` for exactly one cycle. The pulse waits for `pmux_ack` if the select value changed, and goes ahead without it if the select was already 3. During the pulse, `pll_mhz` is twice `req_mhz` for targets 300 to 599, and equals `req_mhz` for targets 600 to 3000.
- R5: `pmux_sel` stays at 3 from acceptance until `pll_lock` is seen. After lock, `smux_sel` becomes 1 for targets below 600 and 0 otherwise. When this value differs from the previous one, the block waits for `smux_ack`.
- R6: Once the secondary selector is settled, `pmux_sel` becomes 0 for targets below 600 and 1 otherwise. After `pmux_ack`, `done` pulses for one cycle and `busy` falls in that cycle.
- R7: If `pll_lock` is not high on any of the `lock_timeout` clock edges that follow the `pll_prog` cycle, the block raises `err_lock`, keeps `pmux_sel` at 3, leaves `smux_sel` unchanged and returns to idle with `busy` low. `err_lock` clears when the next in-range request is accepted.
- R8: If `pll_lock` is first high on the last edge of the timeout window, the lock is taken and the sequence completes normally.
- R9: Requests are accepted only while idle. A request that arrives during a sequence, whether in range or not, causes no `err_range`, no additional `pll_prog` and no change to the final selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Rate request strobe |
| req_mhz | input | MHZ_W | Requested CPU frequency in MHz |
| lock_timeout | input | TMO_W | Lock wait window in cycles, at least 1 |
| pll_lock | input | 1 | Primary PLL lock indication |
| smux_ack | input | 1 | Secondary selector switch acknowledge |
| pmux_ack | input | 1 | Primary selector switch acknowledge |
| smux_sel | output | 1 | Secondary selector: 0 crystal, 1 PLL divided by two |
| pmux_sel | output | 2 | Primary selector: 0 secondary, 1 PLL early, 2 droop path, 3 alternate PLL |
| pll_prog | output | 1 | One-cycle PLL program command |
| pll_mhz | output | MHZ_W | VCO rate for the program command |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_range | output | 1 | One-cycle pulse for a refused target |
| err_lock | output | 1 | Lock timeout flag |

## Verification
Two events can fall on the same clock edge: the arrival of PLL lock and the expiry of the lock timeout. The bench sets the lock delay equal to the timeout window, and then one cycle longer. In the first case lock must win, producing a normal completion with the expected selects. In the second case the block must stay on the alternate PLL with `err_lock` raised. A scoreboard records the expected program rate and final selects for every request, so an unexpected extra program pulse caused by a request during a busy sequence also shows up as a mismatch.

// File: rtl/cpu_clk_seq.sv
module cpu_clk_seq #(
  parameter int MHZ_W   = 12,
  parameter int TMO_W   = 16,
  parameter int LO_MHZ  = 300,
  parameter int VCO_MIN = 600,
  parameter int VCO_MAX = 3000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [MHZ_W-1:0] req_mhz,
  input  logic [TMO_W-1:0] lock_timeout,
  input  logic             pll_lock,
  input  logic             smux_ack,
  input  logic             pmux_ack,
  output logic             smux_sel,
  output logic [1:0]       pmux_sel,
  output logic             pll_prog,
  output logic [MHZ_W-1:0] pll_mhz,
  output logic             busy,
  output logic             done,
  output logic             err_range,
  output logic             err_lock
);
  typedef enum logic [2:0] {
    S_IDLE, S_ALT, S_PROG, S_LOCK, S_SMUX, S_BACK, S_DONE
  } st_t;

  localparam logic [1:0] SEL_ALT = 2'd3;

  st_t              state;
  logic             div_path;
  logic             chg;
  logic [TMO_W-1:0] cnt;

  wire in_range = (req_mhz >= MHZ_W'(LO_MHZ)) && (req_mhz <= MHZ_W'(VCO_MAX));
  wire low_band = req_mhz < MHZ_W'(VCO_MIN);
  wire [TMO_W-1:0] tmo_last = lock_timeout - 1'b1;

  assign pll_prog = (state == S_PROG);
  assign done     = (state == S_DONE);
  assign busy     = (state != S_IDLE) && (state != S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      smux_sel  <= 1'b0;
      pmux_sel  <= 2'd0;
      pll_mhz   <= '0;
      div_path  <= 1'b0;
      chg       <= 1'b0;
      cnt       <= '0;
      err_range <= 1'b0;
      err_lock  <= 1'b0;
    end else begin
      err_range <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          if (in_range) begin
            div_path <= low_band;
            pll_mhz  <= low_band ? {req_mhz[MHZ_W-2:0], 1'b0} : req_mhz;
            chg      <= (pmux_sel != SEL_ALT);
            pmux_sel <= SEL_ALT;
            err_lock <= 1'b0;
            state    <= S_ALT;
          end else begin
            err_range <= 1'b1;
          end
        end
        S_ALT: if (!chg || pmux_ack) state <= S_PROG;
        S_PROG: begin
          cnt   <= '0;
          state <= S_LOCK;
        end
        S_LOCK: begin
          if (pll_lock) begin
            chg      <= (smux_sel != div_path);
            smux_sel <= div_path;
            state    <= S_SMUX;
          end else if (cnt == tmo_last) begin
            err_lock <= 1'b1;
            state    <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SMUX: if (!chg || smux_ack) begin
          pmux_sel <= div_path ? 2'd0 : 2'd1;
          state    <= S_BACK;
        end
        S_BACK: if (pmux_ack) state <= S_DONE;
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module cpu_clk_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       smux_sel,
  input logic [1:0] pmux_sel,
  input logic       pll_prog,
  input logic       busy,
  input logic       done,
  input logic       err_range,
  input logic       err_lock
);
  // R4
  prog_on_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_prog |-> pmux_sel == 2'd3);
  // R4
  prog_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_prog |=> !pll_prog);
  // R3
  busy_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> pmux_sel == 2'd3);
  // R2
  range_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_range |-> !busy && !pll_prog);
  // R7
  lock_err_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_lock) |-> pmux_sel == 2'd3 && !busy);
  // R6
  done_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && ((pmux_sel == 2'd0 && smux_sel) || (pmux_sel == 2'd1 && !smux_sel)));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind cpu_clk_seq cpu_clk_seq_chk u_chk (.*);

// File: tb/cpu_clk_seq_test.sv
`timescale 1ns/1ps
module cpu_clk_seq_test;
  localparam int TMO = 8;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [11:0] req_mhz = 0;
  logic [15:0] lock_timeout = 16'(TMO);
  logic pll_lock = 0, smux_ack = 0, pmux_ack = 0;
  logic smux_sel, pll_prog, busy, done, err_range, err_lock;
  logic [1:0] pmux_sel;
  logic [11:0] pll_mhz;

  cpu_clk_seq uut (.*);

  always #2 clk = ~clk;

  typedef enum logic [1:0] {K_PROG, K_DONE, K_RANGE, K_LERR} kind_t;
  typedef struct packed {
    kind_t       kind;
    logic [11:0] mhz;
    logic        smux;
    logic [1:0]  pmux;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  int lock_dly = 3;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic pop_cmp(input kind_t k);
    exp_t e;
    if (q.size() == 0) begin
      chk(0, "R9 unexpected event", int'(k), -1);
      return;
    end
    e = q.pop_front();
    chk(e.kind == k, "R2/R4/R6/R7 event kind", int'(k), int'(e.kind));
    if (e.kind != k) return;
    case (k)
      K_PROG: chk(pll_mhz == e.mhz, "R4 vco rate", int'(pll_mhz), int'(e.mhz));
      K_DONE: begin
        chk(pmux_sel == e.pmux, "R6 final pmux", int'(pmux_sel), int'(e.pmux));
        chk(smux_sel == e.smux, "R5 final smux", int'(smux_sel), int'(e.smux));
      end
      K_LERR: chk(pmux_sel == 2'd3, "R7 stays on alternate", int'(pmux_sel), 3);
      default: ;
    endcase
  endtask

  // monitor
  initial begin
    logic prev_lerr;
    prev_lerr = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (pll_prog) pop_cmp(K_PROG);
        if (done) pop_cmp(K_DONE);
        if (err_range) pop_cmp(K_RANGE);
        if (err_lock && !prev_lerr) pop_cmp(K_LERR);
        prev_lerr = err_lock;
      end
    end
  end

  // acknowledge and lock responders
  initial begin
    logic [1:0] pp; int pc;
    pp = 0; pc = 0;
    forever begin
      @(negedge clk);
      pmux_ack = 0;
      if (pmux_sel != pp) begin pp = pmux_sel; pc = 2; end
      else if (pc > 0) begin pc--; if (pc == 0) pmux_ack = 1; end
    end
  end
  initial begin
    logic sp; int sc;
    sp = 0; sc = 0;
    forever begin
      @(negedge clk);
      smux_ack = 0;
      if (smux_sel != sp) begin sp = smux_sel; sc = 2; end
      else if (sc > 0) begin sc--; if (sc == 0) smux_ack = 1; end
    end
  end
  initial begin
    int lc;
    lc = 0;
    forever begin
      @(negedge clk);
      if (pll_prog) begin pll_lock = 0; lc = lock_dly; end
      else if (lc > 0) begin lc--; if (lc == 0) pll_lock = 1; end
    end
  end

  task automatic run_req(input int mhz, input int ld, input bit inject);
    exp_t e;
    bit lo, ok_rng, seen_lock;
    logic s0; logic [1:0] p0;
    lock_dly = ld;
    ok_rng = (mhz >= 300) && (mhz <= 3000);
    lo = mhz < 600;
    s0 = smux_sel; p0 = pmux_sel;
    if (!ok_rng) begin
      e = '{K_RANGE, 12'd0, 1'b0, 2'd0}; q.push_back(e);
    end else begin
      e = '{K_PROG, lo ? 12'(2*mhz) : 12'(mhz), 1'b0, 2'd0}; q.push_back(e);
      if (ld <= TMO) e = '{K_DONE, 12'd0, lo, lo ? 2'd0 : 2'd1};
      else e = '{K_LERR, 12'd0, 1'b0, 2'd3};
      q.push_back(e);
    end
    @(negedge clk); req_valid = 1; req_mhz = 12'(mhz);
    @(negedge clk); req_valid = 0;
    if (!ok_rng) begin
      chk(!busy, "R2 busy stays low", int'(busy), 0);
      chk(pmux_sel == p0 && smux_sel == s0, "R2 selects unchanged", int'({smux_sel, pmux_sel}), int'({s0, p0}));
      @(negedge clk);
      chk(!err_range, "R2 one-cycle pulse", int'(err_range), 0);
      repeat (2) @(negedge clk);
      return;
    end
    chk(busy && pmux_sel == 2'd3, "R3 accept to alternate", int'({busy, pmux_sel}), 7);
    chk(!err_lock, "R7 flag cleared on accept", int'(err_lock), 0);
    if (inject) begin
      @(negedge clk); req_valid = 1; req_mhz = 12'd3500;
      @(negedge clk); req_mhz = 12'd800;
      @(negedge clk); req_valid = 0;
    end
    seen_lock = 0;
    while (busy) begin
      if (pll_lock && !seen_lock) begin
        seen_lock = 1;
        chk(pmux_sel == 2'd3, "R5 on alternate until lock", int'(pmux_sel), 3);
      end
      @(negedge clk);
    end
    if (ld > TMO) begin
      chk(err_lock && pmux_sel == 2'd3, "R7 timeout state", int'({err_lock, pmux_sel}), 7);
      chk(smux_sel == s0, "R7 smux unchanged", int'(smux_sel), int'(s0));
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(smux_sel == 0 && pmux_sel == 0, "R1 reset selects", int'({smux_sel, pmux_sel}), 0);
    chk(!busy && !done && !pll_prog && !err_range && !err_lock, "R1 reset flags",
        int'({busy, done, pll_prog, err_range, err_lock}), 0);
    run_req(299, 3, 0);    // R2 just below
    run_req(3001, 3, 0);   // R2 just above
    run_req(300, 3, 0);    // R4 low band floor
    run_req(599, 4, 0);    // R5 low band top
    run_req(600, 2, 0);    // R6 high band floor
    run_req(3000, 3, 1);   // R9 requests during busy
    run_req(1500, TMO, 0); // R8 lock on last window edge
    run_req(1200, TMO + 1, 0); // R7 timeout
    run_req(450, 2, 0);    // R7 recovery, already on alternate
    run_req(0, 3, 0);      // R2 zero
    chk(q.size() == 0, "R4/R6 missing events", q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule